// File: doc/BRIEF.md
# Error Barrier Deferral Unit

This unit models what an error synchronization barrier does to a pending physical asynchronous system error. It holds the pending-error flag, which a raise strobe sets. When a barrier strobe arrives, the unit works out which privilege level the error is routed to, using the routing control bits. It then decides whether the error is masked at the current privilege level.

If the error is pending and masked, the barrier defers it. The unit writes a 64-bit deferred-error record from the 25-bit syndrome and drops the pending flag. It also pulses a clear strobe. An unmasked or absent error leaves everything untouched, and exception entry is left to the surrounding logic.

All pins are plain control and status. Nothing flows as a stream, so there is no valid/ready handshake. A barrier is accepted in any cycle and there is no back-pressure. Support for host virtualization and for the double-fault feature is selected by parameters. Both are enabled by default.

Top module: `err_defer_unit`

## Requirements
- R1: After reset, `record_o` is zero and `clr_o` and `pending_o` are 0.
- R2: Levels are 2-bit unsigned values 0 to 3. The routing target is level 3 when `el3_present_i` and `el3_route_i` are both 1. Otherwise it is level 2 when `el2_enabled_i` is 1 and either `trap_gen_i` or `abort_route_i` is 1. Otherwise it is level 1.
- R3: With target level 1, the mask window covers current levels 0 and 1 only.
- R4: With host virtualization supported, target level 2 and `host_en_i` = `trap_gen_i` = 1, the mask window covers current levels 0 and 2. In every other case not covered by R3, the window covers only the current level equal to the target.
- R5: `amask_i` counts only when it is 1. It does not count when the double-fault feature is present, `el3_route_i` = 1, the current level is 3 and `nm_abort_i` = 1.
- R6: The error is masked in any of these three cases:
  - the target is numerically below `cur_lvl_i`;
  - `halted_i` is 1, or `dbg_intdis_i[target]` is 1 (bit index equals the target level);
  - the current level is inside the mask window and the mask bit counts.
- R7: A barrier that finds the error pending and masked writes `record_o` one cycle later. Bit 31 is 1, bits 24:0 are `syndrome_i[24:0]`, and all other bits are 0. `clr_o` pulses high for exactly that cycle.
- R8: After a deferring barrier, `pending_o` reads 0 in the following cycle.
- R9: A barrier with no pending error, or with an unmasked error, leaves `record_o` and `pending_o` unchanged and does not raise `clr_o`.
- R10: `raise_i` high in the same cycle as a deferring barrier wins, so `pending_o` stays 1. The barrier decision uses the flag as it was before that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| barrier_i | input | 1 | Barrier strobe |
| cur_lvl_i | input | 2 | Current privilege level |
| amask_i | input | 1 | Asynchronous error mask bit |
| el3_present_i | input | 1 | Level 3 exists |
| el3_route_i | input | 1 | Route external aborts to level 3 |
| el2_enabled_i | input | 1 | Level 2 is enabled |
| trap_gen_i | input | 1 | Trap-general control |
| abort_route_i | input | 1 | Route aborts to level 2 |
| host_en_i | input | 1 | Host-enable control |
| nm_abort_i | input | 1 | Non-maskable abort control |
| halted_i | input | 1 | Core halted in debug |
| dbg_intdis_i | input | 4 | Debug interrupt disable, one bit per target level |
| raise_i | input | 1 | Sets the pending error |
| syndrome_i | input | 25 | Error syndrome |
| record_o | output | 64 | Deferred-error record |
| clr_o | output | 1 | Pending-clear pulse |
| pending_o | output | 1 | Pending-error flag |

## Verification
Every result lands one clock edge after the barrier cycle: `record_o`, `clr_o` and the new `pending_o` are all registered at that edge. The bench drives inputs on the falling edge. It samples all three outputs on the falling edge that follows the barrier's rising edge, which is half a cycle after they update. One cycle later it samples `clr_o` again to confirm the pulse lasted a single cycle. A raise is applied one cycle before the barrier, so the pending flag is already visible when the barrier decision is made. The R10 case raises in the barrier cycle itself.

// File: rtl/edu_pkg.sv
package edu_pkg;
  localparam int LVL_W   = 2;
  localparam int N_LVL   = 1 << LVL_W;
  localparam int SYN_W   = 25;
  localparam int REC_W   = 64;
  localparam int FLAG_BIT = 31;

  typedef logic [LVL_W-1:0] lvl_t;

  localparam lvl_t LVL0 = 2'd0;
  localparam lvl_t LVL1 = 2'd1;
  localparam lvl_t LVL2 = 2'd2;
  localparam lvl_t LVL3 = 2'd3;
endpackage

// File: rtl/edu_route.sv
module edu_route
  import edu_pkg::*;
(
  input  logic el3_present_i,
  input  logic el3_route_i,
  input  logic el2_enabled_i,
  input  logic trap_gen_i,
  input  logic abort_route_i,
  output lvl_t target_o
);
  logic to_top, to_hyp;

  always_comb begin
    to_top = el3_present_i & el3_route_i;
    to_hyp = el2_enabled_i & (trap_gen_i | abort_route_i);
    if (to_top)      target_o = LVL3;
    else if (to_hyp) target_o = LVL2;
    else             target_o = LVL1;
  end
endmodule

// File: rtl/edu_mask.sv
module edu_mask
  import edu_pkg::*;
#(
  parameter bit HOST_VIRT = 1'b1,
  parameter bit DBL_FAULT = 1'b1
) (
  input  lvl_t             cur_lvl_i,
  input  lvl_t             target_i,
  input  logic             amask_i,
  input  logic             el3_route_i,
  input  logic             trap_gen_i,
  input  logic             host_en_i,
  input  logic             nm_abort_i,
  input  logic             halted_i,
  input  logic [N_LVL-1:0] dbg_intdis_i,
  output logic             masked_o
);
  logic host_case;
  logic nm_override;
  logic in_window;
  logic bit_counts;
  logic below;
  logic dbg_block;

  generate
    if (HOST_VIRT) begin : g_hv
      assign host_case = (target_i == LVL2) & host_en_i & trap_gen_i;
    end else begin : g_no_hv
      assign host_case = 1'b0;
    end
  endgenerate

  generate
    if (DBL_FAULT) begin : g_df
      assign nm_override = el3_route_i & (cur_lvl_i == LVL3) & nm_abort_i;
    end else begin : g_no_df
      assign nm_override = 1'b0;
    end
  endgenerate

  always_comb begin
    if (target_i == LVL1)
      in_window = (cur_lvl_i == LVL0) | (cur_lvl_i == LVL1);
    else if (host_case)
      in_window = (cur_lvl_i == LVL0) | (cur_lvl_i == LVL2);
    else
      in_window = (cur_lvl_i == target_i);

    bit_counts = amask_i & ~nm_override;
    below      = (target_i < cur_lvl_i);
    dbg_block  = halted_i | dbg_intdis_i[target_i];
    masked_o   = below | dbg_block | (in_window & bit_counts);
  end
endmodule

// File: rtl/edu_record.sv
module edu_record
  import edu_pkg::*;
#(
  parameter int SW = SYN_W,
  parameter int RW = REC_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          barrier_i,
  input  logic          masked_i,
  input  logic          raise_i,
  input  logic [SW-1:0] syndrome_i,
  output logic [RW-1:0] record_o,
  output logic          clr_o,
  output logic          pending_o
);
  logic          defer;
  logic [RW-1:0] rec_next;

  always_comb begin
    defer    = barrier_i & pending_o & masked_i;
    rec_next = '0;
    rec_next[FLAG_BIT]  = 1'b1;
    rec_next[SW-1:0]    = syndrome_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      record_o  <= '0;
      clr_o     <= 1'b0;
      pending_o <= 1'b0;
    end else begin
      clr_o <= defer;
      if (defer) record_o <= rec_next;
      if (raise_i)    pending_o <= 1'b1;
      else if (defer) pending_o <= 1'b0;
    end
  end
endmodule

// File: rtl/err_defer_unit.sv
module err_defer_unit
  import edu_pkg::*;
#(
  parameter bit HOST_VIRT = 1'b1,
  parameter bit DBL_FAULT = 1'b1,
  parameter int SW        = SYN_W,
  parameter int RW        = REC_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             barrier_i,
  input  logic [LVL_W-1:0] cur_lvl_i,
  input  logic             amask_i,
  input  logic             el3_present_i,
  input  logic             el3_route_i,
  input  logic             el2_enabled_i,
  input  logic             trap_gen_i,
  input  logic             abort_route_i,
  input  logic             host_en_i,
  input  logic             nm_abort_i,
  input  logic             halted_i,
  input  logic [N_LVL-1:0] dbg_intdis_i,
  input  logic             raise_i,
  input  logic [SW-1:0]    syndrome_i,
  output logic [RW-1:0]    record_o,
  output logic             clr_o,
  output logic             pending_o
);
  lvl_t target;
  logic masked;

  edu_route u_route (
    .el3_present_i (el3_present_i),
    .el3_route_i   (el3_route_i),
    .el2_enabled_i (el2_enabled_i),
    .trap_gen_i    (trap_gen_i),
    .abort_route_i (abort_route_i),
    .target_o      (target)
  );

  edu_mask #(.HOST_VIRT(HOST_VIRT), .DBL_FAULT(DBL_FAULT)) u_mask (
    .cur_lvl_i    (cur_lvl_i),
    .target_i     (target),
    .amask_i      (amask_i),
    .el3_route_i  (el3_route_i),
    .trap_gen_i   (trap_gen_i),
    .host_en_i    (host_en_i),
    .nm_abort_i   (nm_abort_i),
    .halted_i     (halted_i),
    .dbg_intdis_i (dbg_intdis_i),
    .masked_o     (masked)
  );

  edu_record #(.SW(SW), .RW(RW)) u_rec (
    .clk        (clk),
    .rst_n      (rst_n),
    .barrier_i  (barrier_i),
    .masked_i   (masked),
    .raise_i    (raise_i),
    .syndrome_i (syndrome_i),
    .record_o   (record_o),
    .clr_o      (clr_o),
    .pending_o  (pending_o)
  );
endmodule

// File: rtl/edu_chk.sv
module edu_chk
  import edu_pkg::*;
#(
  parameter int SW = SYN_W,
  parameter int RW = REC_W
) (
  input logic          clk,
  input logic          rst_n,
  input logic          barrier_i,
  input logic          raise_i,
  input logic [SW-1:0] syndrome_i,
  input logic [RW-1:0] record_o,
  input logic          clr_o,
  input logic          pending_o
);
  // R7
  clr_needs_pending_barrier_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_o |-> ($past(barrier_i) && $past(pending_o)));

  // R7
  record_format_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_o |-> (record_o[FLAG_BIT] && record_o[RW-1:FLAG_BIT+1] == '0
               && record_o[FLAG_BIT-1:SW] == '0
               && record_o[SW-1:0] == $past(syndrome_i)));

  // R9
  record_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_o |-> $stable(record_o));

  // R8
  pending_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_o && !$past(raise_i)) |-> !pending_o);

  // R10
  raise_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    raise_i |=> pending_o);
endmodule

bind err_defer_unit edu_chk #(.SW(SW), .RW(RW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .barrier_i  (barrier_i),
  .raise_i    (raise_i),
  .syndrome_i (syndrome_i),
  .record_o   (record_o),
  .clr_o      (clr_o),
  .pending_o  (pending_o)
);

// File: tb/sim_err_defer_unit.sv
`timescale 1ns/1ps
module sim_err_defer_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        barrier_i = 0, amask_i = 0, el3_present_i = 0, el3_route_i = 0;
  logic        el2_enabled_i = 0, trap_gen_i = 0, abort_route_i = 0, host_en_i = 0;
  logic        nm_abort_i = 0, halted_i = 0, raise_i = 0;
  logic [1:0]  cur_lvl_i = 0;
  logic [3:0]  dbg_intdis_i = 0;
  logic [24:0] syndrome_i = 0;
  logic [63:0] record_o;
  logic        clr_o, pending_o;

  int n_cmp = 0, n_bad = 0, cycles = 0;
  logic [63:0] exp_rec = '0;
  bit exp_pend = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  err_defer_unit u0 (.*);

  function automatic bit f_masked(input logic [1:0] lvl);
    logic [1:0] t;
    bit act, cnt;
    if (el3_present_i && el3_route_i) t = 2'd3;
    else if (el2_enabled_i && (trap_gen_i || abort_route_i)) t = 2'd2;
    else t = 2'd1;
    if (t == 2'd1) act = (lvl <= 2'd1);
    else if (t == 2'd2 && host_en_i && trap_gen_i) act = (lvl == 2'd0 || lvl == 2'd2);
    else act = (lvl == t);
    cnt = amask_i && !(el3_route_i && lvl == 2'd3 && nm_abort_i);
    return (t < lvl) || halted_i || dbg_intdis_i[t] || (act && cnt);
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clear_ctl();
    amask_i = 0; el3_present_i = 0; el3_route_i = 0; el2_enabled_i = 0;
    trap_gen_i = 0; abort_route_i = 0; host_en_i = 0; nm_abort_i = 0;
    halted_i = 0; dbg_intdis_i = 0; cur_lvl_i = 0;
  endtask

  // called at a falling edge with controls already set
  task automatic step(input string req, input bit pre_raise, input bit same_raise);
    bit defer;
    if (pre_raise) begin
      raise_i = 1;
      @(posedge clk); @(negedge clk);
      raise_i = 0;
      exp_pend = 1;
    end
    barrier_i  = 1;
    raise_i    = same_raise;
    syndrome_i = 25'($urandom);
    defer = exp_pend && f_masked(cur_lvl_i);
    if (defer) exp_rec = {32'd0, 1'b1, 6'd0, syndrome_i};
    if (same_raise) exp_pend = 1;
    else if (defer) exp_pend = 0;
    @(posedge clk); @(negedge clk);
    barrier_i = 0; raise_i = 0;
    check({req, " record"}, record_o, exp_rec);
    check({req, " clr"}, 64'(clr_o), 64'(defer));
    check({req, " pending"}, 64'(pending_o), 64'(exp_pend));
    @(posedge clk); @(negedge clk);
    check("R7 clr one cycle", 64'(clr_o), 64'd0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual %0d expected <150000 cycles", cycles);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 record", record_o, 64'd0);
    check("R1 clr", 64'(clr_o), 64'd0);
    check("R1 pending", 64'(pending_o), 64'd0);

    // R9 barrier with nothing pending, masked
    clear_ctl(); amask_i = 1; cur_lvl_i = 1;
    step("R9 none pending", 0, 0);
    // R2 target 3, current 2, unmasked
    clear_ctl(); el3_present_i = 1; el3_route_i = 1; cur_lvl_i = 2;
    step("R2 target3 unmasked", 1, 0);
    // R2 target 2 below current 3
    clear_ctl(); el2_enabled_i = 1; abort_route_i = 1; cur_lvl_i = 3;
    step("R2 target2 below", 0, 0);
    // R3 target 1, level 1, mask set
    clear_ctl(); amask_i = 1; cur_lvl_i = 1;
    step("R3 level1 masked", 1, 0);
    // R3 level 0, mask clear
    clear_ctl(); cur_lvl_i = 0;
    step("R3 level0 unmasked", 1, 0);
    // R4 host case, level 0 in window
    clear_ctl(); el2_enabled_i = 1; trap_gen_i = 1; host_en_i = 1; amask_i = 1;
    cur_lvl_i = 0;
    step("R4 host window", 0, 0);
    // R4 no host enable: level 0 outside window
    clear_ctl(); el2_enabled_i = 1; trap_gen_i = 1; amask_i = 1; cur_lvl_i = 0;
    step("R4 plain window", 1, 0);
    // R5 non-maskable override at level 3
    clear_ctl(); el3_present_i = 1; el3_route_i = 1; cur_lvl_i = 3;
    amask_i = 1; nm_abort_i = 1;
    step("R5 override", 0, 0);
    nm_abort_i = 0;
    step("R5 no override", 0, 0);
    // R6 halted and debug disable
    clear_ctl(); halted_i = 1;
    step("R6 halted", 1, 0);
    clear_ctl(); el2_enabled_i = 1; trap_gen_i = 1; cur_lvl_i = 1; dbg_intdis_i = 4'b0100;
    step("R6 dbg intdis", 1, 0);
    // R8 nothing left: second barrier has no effect
    step("R8 already cleared", 0, 0);
    // R10 raise coincides with deferring barrier
    clear_ctl(); amask_i = 1; cur_lvl_i = 0;
    step("R10 raise wins", 1, 1);
    step("R10 follow-up defer", 0, 0);

    // random trials
    for (int i = 0; i < 400; i++) begin
      bit pre, same, m;
      cur_lvl_i     = 2'($urandom);
      amask_i       = 1'($urandom);
      el3_present_i = 1'($urandom);
      el3_route_i   = 1'($urandom);
      el2_enabled_i = 1'($urandom);
      trap_gen_i    = 1'($urandom);
      abort_route_i = 1'($urandom);
      host_en_i     = 1'($urandom);
      nm_abort_i    = 1'($urandom);
      halted_i      = ($urandom % 8) == 0;
      dbg_intdis_i  = (($urandom % 4) == 0) ? 4'($urandom) : 4'd0;
      pre  = ($urandom % 4) != 0;
      same = ($urandom % 10) == 0;
      m = f_masked(cur_lvl_i);
      step(((pre || exp_pend) && m) ? "R7 random defer" : "R9 random keep", pre, same);
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule